// File: doc/BRIEF.md
# Configuration Access Trap with System-Management Interrupt

This block sits beside the configuration-space path of a multi-function device. It decodes every configuration access by function number and register index. An 8-bit trap-enable register arms trapping separately for functions 2, 3, 4 and 5. When an access reaches an armed function, the block latches a system-management event into a two-level status hierarchy and raises a level SMI request.

A trapped write is held back, so the target register keeps its old contents. A trapped read still goes to the target and returns the target's data; the block only observes it. The block's own two registers sit in function 0. They are the trap-enable register at index 41h and a bus-policy register at index 40h. Accesses to these two registers are served locally and never forwarded.

The policy register holds two bits. One cascades an incoming parity error onto a system-error output. The other lets the block claim interrupt-acknowledge cycles. Software services the SMI by reading the second-level status word, which clears it. The top-level bit and the SMI request then fall on the following clock edge.

Top module: `cfgtrap_top`

## Requirements
- R1: After reset the trap-enable register reads 00h and the policy register reads 39h. Both status words are 0, and smi_req and serr_out are low.
- R2: A write to function 0, index 41h stores only bits 5:2 into the trap-enable register. Bit n arms function n. The other bits read back as 0.
- R3: A write to function 0, index 40h changes only policy bits 4, 1 and 0. Bits 5 and 3 always read 1, and bits 7:6 and 2 always read 0.
- R4: An access to function f (2 to 5) while trap-enable bit f is 1 sets bit 5 of sts_sec and bit 9 of sts_top at the next clock edge. Every other status bit stays 0.
- R5: A trapped write is not forwarded: fwd_valid is low in that cycle.
- R6: A trapped read is forwarded with fwd_valid high and fwd_write low, and acc_rdata equals tgt_rdata.
- R7: An access to function 0, 1, 6 or 7, or to a function whose enable bit is 0, is forwarded unchanged and records no status.
- R8: Status is sticky. A pulse on sts_rd_sec clears the second-level bit at that edge unless a new trap arrives in the same cycle. The top-level bit clears one edge after the second-level bit is 0. smi_req follows the top-level bit.
- R9: serr_out goes high one clock after perr_in is high while policy bit 1 is 1. Otherwise it stays low.
- R10: inta_claim equals inta_cycle AND policy bit 0, in the same cycle.
- R11: Accesses to the block's own registers are never forwarded, and acc_rdata returns the local register. A write to the trap-enable register affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Configuration access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_func | input | 3 | Target function number |
| acc_idx | input | 8 | Target register index |
| acc_wdata | input | 8 | Write data |
| tgt_rdata | input | 8 | Read data returned by the target function |
| acc_rdata | output | 8 | Read data to the requester |
| fwd_valid | output | 1 | Access forwarded to the target |
| fwd_write | output | 1 | Forwarded access is a write |
| sts_rd_sec | input | 1 | Software read of the second-level status word (clears it) |
| sts_top | output | 16 | Top-level status word, bit 9 = configuration trap |
| sts_sec | output | 16 | Second-level status word, bit 5 = configuration trap |
| smi_req | output | 1 | System-management interrupt request (level) |
| perr_in | input | 1 | Parity error seen on the bus |
| serr_out | output | 1 | System error output |
| inta_cycle | input | 1 | Interrupt-acknowledge cycle on the bus |
| inta_claim | output | 1 | Block responds to the interrupt-acknowledge cycle |

## Verification
Random accesses spread across all eight function numbers, both directions and random enable masks. These separate armed functions from disarmed ones and from functions 0, 1, 6 and 7, which can never trap. They also show that writes are blocked while reads pass through. Biased accesses to function 0 at indices 40h and 41h exercise the reserved-bit masking and show that a new enable takes effect only on the next access. Random clear pulses, some landing in the same cycle as a new trap, test the set-over-clear priority and the one-edge lag of the top-level bit and the SMI. Random parity-error and interrupt-acknowledge inputs under both policy settings cover the two bus-policy paths.

// File: rtl/cfgtrap_pkg.sv
package cfgtrap_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_POL  = 2'd1,
      SEL_TRAP = 2'd2
   } loc_sel_e;

   // contiguous mask of ones from bit lo up to bit hi
   function automatic logic [31:0] span_mask(input int lo, input int hi);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if (i >= lo && i <= hi) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/cfgtrap_decode.sv
module cfgtrap_decode
   import cfgtrap_pkg::*;
#(
   parameter int FUNC_W    = 3,
   parameter int IDX_W     = 8,
   parameter int DATA_W    = 8,
   parameter int FUNC_LO   = 2,
   parameter int FUNC_HI   = 5,
   parameter int CTRL_FUNC = 0,
   parameter int POL_IDX   = 'h40,
   parameter int TRAP_IDX  = 'h41
) (
   input  logic              acc_valid,
   input  logic [FUNC_W-1:0] acc_func,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [DATA_W-1:0] trap_reg,
   output logic              trap_hit,
   output loc_sel_e          sel
);

   logic [DATA_W-1:0] hit_vec;
   logic              own_func;

   for (genvar f = 0; f < DATA_W; f++) begin : g_fn
      localparam logic IN_RANGE = (f >= FUNC_LO) && (f <= FUNC_HI);
      assign hit_vec[f] = IN_RANGE && acc_valid &&
                          (acc_func == FUNC_W'(f)) && trap_reg[f];
   end

   assign trap_hit = |hit_vec;
   assign own_func = acc_valid && (acc_func == FUNC_W'(CTRL_FUNC));

   always_comb begin
      sel = SEL_NONE;
      if (own_func && acc_idx == IDX_W'(POL_IDX))  sel = SEL_POL;
      if (own_func && acc_idx == IDX_W'(TRAP_IDX)) sel = SEL_TRAP;
   end

endmodule

// File: rtl/cfgtrap_regs.sv
module cfgtrap_regs
   import cfgtrap_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] TRAP_MASK = 8'h3C,
   parameter logic [DATA_W-1:0] POL_MASK  = 8'h13,
   parameter logic [DATA_W-1:0] POL_RST   = 8'h39
) (
   input  logic              clk,
   input  logic              rst_n,
   input  loc_sel_e          sel,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] trap_reg,
   output logic [DATA_W-1:0] pol_reg,
   output logic [DATA_W-1:0] loc_rdata
);

   localparam logic [DATA_W-1:0] POL_FIXED = POL_RST & ~POL_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_reg <= '0;
         pol_reg  <= POL_RST;
      end else if (wr) begin
         if (sel == SEL_TRAP) trap_reg <= wdata & TRAP_MASK;
         if (sel == SEL_POL)  pol_reg  <= (wdata & POL_MASK) | POL_FIXED;
      end
   end

   always_comb begin
      case (sel)
         SEL_POL:  loc_rdata = pol_reg;
         SEL_TRAP: loc_rdata = trap_reg;
         default:  loc_rdata = '0;
      endcase
   end

endmodule

// File: rtl/cfgtrap_status.sv
module cfgtrap_status #(
   parameter int STS_W   = 16,
   parameter int TOP_BIT = 9,
   parameter int SEC_BIT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_ev,
   input  logic             rd_sec,
   output logic [STS_W-1:0] sts_top,
   output logic [STS_W-1:0] sts_sec,
   output logic             smi_req
);

   logic sec_q;
   logic top_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= 1'b0;
         top_q <= 1'b0;
      end else begin
         sec_q <= trap_ev | (sec_q & ~rd_sec);
         top_q <= trap_ev | (top_q & sec_q);
      end
   end

   for (genvar b = 0; b < STS_W; b++) begin : g_sts
      if (b == TOP_BIT) begin : g_top
         assign sts_top[b] = top_q;
      end else begin : g_top0
         assign sts_top[b] = 1'b0;
      end
      if (b == SEC_BIT) begin : g_sec
         assign sts_sec[b] = sec_q;
      end else begin : g_sec0
         assign sts_sec[b] = 1'b0;
      end
   end

   assign smi_req = top_q;

endmodule

// File: rtl/cfgtrap_top.sv
module cfgtrap_top
   import cfgtrap_pkg::*;
#(
   parameter int FUNC_W     = 3,
   parameter int IDX_W      = 8,
   parameter int DATA_W     = 8,
   parameter int FUNC_LO    = 2,
   parameter int FUNC_HI    = 5,
   parameter int CTRL_FUNC  = 0,
   parameter int POL_IDX    = 'h40,
   parameter int TRAP_IDX   = 'h41,
   parameter int POL_RST    = 'h39,
   parameter int POL_MASK   = 'h13,
   parameter int PERR_BIT   = 1,
   parameter int INTA_BIT   = 0,
   parameter int STS_W      = 16,
   parameter int TOP_BIT    = 9,
   parameter int SEC_BIT    = 5,
   parameter bit SERR_FLOP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [FUNC_W-1:0] acc_func,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] tgt_rdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              fwd_valid,
   output logic              fwd_write,
   input  logic              sts_rd_sec,
   output logic [STS_W-1:0]  sts_top,
   output logic [STS_W-1:0]  sts_sec,
   output logic              smi_req,
   input  logic              perr_in,
   output logic              serr_out,
   input  logic              inta_cycle,
   output logic              inta_claim
);

   localparam logic [DATA_W-1:0] TRAP_MASK = DATA_W'(span_mask(FUNC_LO, FUNC_HI));
   localparam logic [DATA_W-1:0] POL_MASK_L = DATA_W'(POL_MASK);
   localparam logic [DATA_W-1:0] POL_RST_L  = DATA_W'(POL_RST);

   // elaboration-time parameter checks
   if (DATA_W > 32 || FUNC_HI >= DATA_W || FUNC_LO > FUNC_HI || FUNC_LO < 0) begin : g_bad_range
      $error("cfgtrap_top: trap function range does not fit the control register");
   end
   if (FUNC_HI >= (1 << FUNC_W)) begin : g_bad_func
      $error("cfgtrap_top: FUNC_W too narrow for trapped functions");
   end
   if (CTRL_FUNC >= FUNC_LO && CTRL_FUNC <= FUNC_HI) begin : g_bad_ctrl
      $error("cfgtrap_top: control function must not be trappable");
   end
   if (TOP_BIT >= STS_W || SEC_BIT >= STS_W) begin : g_bad_sts
      $error("cfgtrap_top: status bit outside status word");
   end
   if (PERR_BIT >= DATA_W || INTA_BIT >= DATA_W || POL_IDX == TRAP_IDX) begin : g_bad_pol
      $error("cfgtrap_top: policy register layout invalid");
   end

   logic              trap_hit;
   loc_sel_e          sel;
   logic              local_acc;
   logic [DATA_W-1:0] trap_reg;
   logic [DATA_W-1:0] pol_reg;
   logic [DATA_W-1:0] loc_rdata;
   logic              serr_raw;

   cfgtrap_decode #(
      .FUNC_W(FUNC_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
      .FUNC_LO(FUNC_LO), .FUNC_HI(FUNC_HI), .CTRL_FUNC(CTRL_FUNC),
      .POL_IDX(POL_IDX), .TRAP_IDX(TRAP_IDX)
   ) u_dec (
      .acc_valid(acc_valid),
      .acc_func (acc_func),
      .acc_idx  (acc_idx),
      .trap_reg (trap_reg),
      .trap_hit (trap_hit),
      .sel      (sel)
   );

   assign local_acc = (sel != SEL_NONE);

   cfgtrap_regs #(
      .DATA_W(DATA_W), .TRAP_MASK(TRAP_MASK),
      .POL_MASK(POL_MASK_L), .POL_RST(POL_RST_L)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .wr       (acc_write),
      .wdata    (acc_wdata),
      .trap_reg (trap_reg),
      .pol_reg  (pol_reg),
      .loc_rdata(loc_rdata)
   );

   cfgtrap_status #(
      .STS_W(STS_W), .TOP_BIT(TOP_BIT), .SEC_BIT(SEC_BIT)
   ) u_sts (
      .clk    (clk),
      .rst_n  (rst_n),
      .trap_ev(trap_hit),
      .rd_sec (sts_rd_sec),
      .sts_top(sts_top),
      .sts_sec(sts_sec),
      .smi_req(smi_req)
   );

   // forwarding: own registers stay local, trapped writes are dropped
   assign fwd_valid = acc_valid && !local_acc && !(trap_hit && acc_write);
   assign fwd_write = fwd_valid && acc_write;
   assign acc_rdata = local_acc ? loc_rdata : tgt_rdata;

   // bus policy paths
   assign serr_raw   = perr_in && pol_reg[PERR_BIT];
   assign inta_claim = inta_cycle && pol_reg[INTA_BIT];

   if (SERR_FLOP) begin : g_serr_ff
      always_ff @(posedge clk) begin
         if (!rst_n) serr_out <= 1'b0;
         else        serr_out <= serr_raw;
      end
   end else begin : g_serr_comb
      assign serr_out = serr_raw;
   end

endmodule

// File: rtl/cfgtrap_chk.sv
module cfgtrap_chk #(
   parameter int FUNC_W  = 3,
   parameter int DATA_W  = 8,
   parameter int STS_W   = 16,
   parameter int TOP_BIT = 9,
   parameter int SEC_BIT = 5,
   parameter int FUNC_LO = 2,
   parameter int FUNC_HI = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [FUNC_W-1:0] acc_func,
   input logic [DATA_W-1:0] tgt_rdata,
   input logic [DATA_W-1:0] acc_rdata,
   input logic              fwd_valid,
   input logic              fwd_write,
   input logic              trap_hit,
   input logic [DATA_W-1:0] trap_reg,
   input logic [STS_W-1:0]  sts_top,
   input logic [STS_W-1:0]  sts_sec,
   input logic              smi_req,
   input logic              perr_in,
   input logic              serr_out
);

   localparam logic [DATA_W-1:0] LEGAL = DATA_W'(cfgtrap_pkg::span_mask(FUNC_LO, FUNC_HI));

   AST_TRAP_REG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_reg & ~LEGAL) == '0);                                            // R2
   AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_hit |=> (sts_sec[SEC_BIT] && sts_top[TOP_BIT]));                  // R4
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_hit && acc_write) |-> !fwd_valid);                               // R5
   AST_RD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_hit && !acc_write) |-> (fwd_valid && !fwd_write && acc_rdata == tgt_rdata)); // R6
   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (acc_func < FUNC_W'(FUNC_LO) || acc_func > FUNC_W'(FUNC_HI))) |-> !trap_hit); // R7
   AST_SMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_sec[SEC_BIT] && !trap_hit) |=> !smi_req);                        // R8
   AST_SERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      serr_out |-> $past(perr_in));                                          // R9

endmodule

bind cfgtrap_top cfgtrap_chk #(
   .FUNC_W(FUNC_W), .DATA_W(DATA_W), .STS_W(STS_W),
   .TOP_BIT(TOP_BIT), .SEC_BIT(SEC_BIT), .FUNC_LO(FUNC_LO), .FUNC_HI(FUNC_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_func(acc_func), .tgt_rdata(tgt_rdata), .acc_rdata(acc_rdata),
   .fwd_valid(fwd_valid), .fwd_write(fwd_write), .trap_hit(trap_hit),
   .trap_reg(trap_reg), .sts_top(sts_top), .sts_sec(sts_sec),
   .smi_req(smi_req), .perr_in(perr_in), .serr_out(serr_out)
);

// File: tb/cfgtrap_top_tb.sv
`timescale 1ns/1ps
module cfgtrap_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  acc_func = '0;
   logic [7:0]  acc_idx = '0, acc_wdata = '0, tgt_rdata = '0;
   logic [7:0]  acc_rdata;
   logic        fwd_valid, fwd_write;
   logic        sts_rd_sec = 1'b0;
   logic [15:0] sts_top, sts_sec;
   logic        smi_req;
   logic        perr_in = 1'b0, serr_out;
   logic        inta_cycle = 1'b0, inta_claim;

   int n_chk = 0;
   int n_fail = 0;

   // bench model state
   logic [7:0] m_trap, m_pol;
   logic       m_sec, m_top, m_serr;

   always #2 clk = ~clk;

   cfgtrap_top u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_func(acc_func), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
      .tgt_rdata(tgt_rdata), .acc_rdata(acc_rdata), .fwd_valid(fwd_valid),
      .fwd_write(fwd_write), .sts_rd_sec(sts_rd_sec), .sts_top(sts_top),
      .sts_sec(sts_sec), .smi_req(smi_req), .perr_in(perr_in),
      .serr_out(serr_out), .inta_cycle(inta_cycle), .inta_claim(inta_claim)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic is_hit(input logic v, input logic [2:0] f, input logic [7:0] tr);
      return v && (f >= 3'd2) && (f <= 3'd5) && tr[f];
   endfunction

   function automatic logic [1:0] loc_kind(input logic v, input logic [2:0] f, input logic [7:0] idx);
      if (!v || f != 3'd0) return 2'd0;
      if (idx == 8'h40) return 2'd1;
      if (idx == 8'h41) return 2'd2;
      return 2'd0;
   endfunction

   task automatic model_reset();
      m_trap = 8'h00; m_pol = 8'h39; m_sec = 1'b0; m_top = 1'b0; m_serr = 1'b0;
   endtask

   task automatic step(input logic v, input logic w, input logic [2:0] f,
                       input logic [7:0] idx, input logic [7:0] wd, input logic [7:0] tg,
                       input logic rs, input logic pe, input logic ia);
      logic       hit, exp_fv;
      logic [1:0] lk;
      logic [7:0] exp_rd;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_func = f; acc_idx = idx; acc_wdata = wd;
      tgt_rdata = tg; sts_rd_sec = rs; perr_in = pe; inta_cycle = ia;
      #1;
      hit    = is_hit(v, f, m_trap);
      lk     = loc_kind(v, f, idx);
      exp_fv = v && (lk == 2'd0) && !(hit && w);
      exp_rd = (lk == 2'd1) ? m_pol : (lk == 2'd2) ? m_trap : tg;
      if (lk != 2'd0)  chk("R11 fwd_valid local", {31'd0, fwd_valid}, 32'd0);
      else if (hit && w) chk("R5 fwd_valid trapped write", {31'd0, fwd_valid}, 32'd0);
      else if (hit)    chk("R6 fwd_valid trapped read", {31'd0, fwd_valid}, {31'd0, exp_fv});
      else             chk("R7 fwd_valid untrapped", {31'd0, fwd_valid}, {31'd0, exp_fv});
      chk("R6 fwd_write", {31'd0, fwd_write}, {31'd0, exp_fv && w});
      if (lk == 2'd1)      chk("R3 policy readback", {24'd0, acc_rdata}, {24'd0, exp_rd});
      else if (lk == 2'd2) chk("R2 trap reg readback", {24'd0, acc_rdata}, {24'd0, exp_rd});
      else                 chk("R6 rdata passthrough", {24'd0, acc_rdata}, {24'd0, exp_rd});
      chk("R10 inta_claim", {31'd0, inta_claim}, {31'd0, ia && m_pol[0]});
      // next state of the model
      m_top  = hit | (m_top & m_sec);
      m_sec  = hit | (m_sec & ~rs);
      m_serr = pe && m_pol[1];
      if (w && lk == 2'd2) m_trap = wd & 8'h3C;
      if (w && lk == 2'd1) m_pol  = (wd & 8'h13) | 8'h28;
      @(posedge clk);
      #1;
      chk("R4 sts_sec", {16'd0, sts_sec}, {16'd0, 10'd0, m_sec, 5'd0});
      chk("R8 sts_top", {16'd0, sts_top}, {16'd0, 6'd0, m_top, 9'd0});
      chk("R8 smi_req", {31'd0, smi_req}, {31'd0, m_top});
      chk("R9 serr_out", {31'd0, serr_out}, {31'd0, m_serr});
   endtask

   task automatic idle(); step(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); endtask

   initial begin : watchdog
      #(4ns * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 sts_top", {16'd0, sts_top}, 32'd0);
      chk("R1 sts_sec", {16'd0, sts_sec}, 32'd0);
      chk("R1 smi_req", {31'd0, smi_req}, 32'd0);
      chk("R1 serr_out", {31'd0, serr_out}, 32'd0);
      acc_valid = 1'b1; acc_func = 3'd0; acc_idx = 8'h41; #1;
      chk("R1 trap reg", {24'd0, acc_rdata}, 32'h00);
      acc_idx = 8'h40; #1;
      chk("R1 policy reg", {24'd0, acc_rdata}, 32'h39);
      acc_valid = 1'b0;

      // directed: disarmed function accesses do nothing (R7)
      for (int f = 0; f < 8; f++) step(1'b1, 1'b1, 3'(f), 8'h10, 8'hAA, 8'h55, 1'b0, 1'b0, 1'b0);
      // R2: write all ones, only 5:2 stick
      step(1'b1, 1'b1, 3'd0, 8'h41, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd0, 8'h41, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
      // R3: policy write all zeros, then all ones
      step(1'b1, 1'b1, 3'd0, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      step(1'b1, 1'b0, 3'd0, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      step(1'b1, 1'b1, 3'd0, 8'h40, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1);
      step(1'b1, 1'b0, 3'd0, 8'h40, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
      // R5 trapped write on each function, R6 trapped read
      for (int f = 2; f < 6; f++) begin
         step(1'b1, 1'b1, 3'(f), 8'h20, 8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0);
         step(1'b1, 1'b0, 3'(f), 8'h20, 8'h00, 8'hC3, 1'b0, 1'b0, 1'b0);
      end
      // R8: clear, top lags one edge
      step(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      idle(); idle();
      // R8: clear in the same cycle as a new trap, set wins
      step(1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 3'd4, 8'h00, 8'h00, 8'h22, 1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      idle();
      // R11: disarm only function 4, then access it
      step(1'b1, 1'b1, 3'd0, 8'h41, 8'h2C, 8'h00, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 3'd4, 8'h08, 8'h77, 8'h00, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 3'd5, 8'h08, 8'h77, 8'h00, 1'b0, 1'b0, 1'b0);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         logic [2:0] f;
         logic [7:0] idx;
         f   = 3'($urandom_range(0, 7));
         idx = 8'($urandom);
         if (f == 3'd0 && $urandom_range(0, 1) == 1) idx = ($urandom_range(0, 1) == 1) ? 8'h40 : 8'h41;
         step($urandom_range(0, 3) != 0, 1'($urandom), f, idx, 8'($urandom), 8'($urandom),
              $urandom_range(0, 5) == 0, 1'($urandom), 1'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule